// File: doc/BRIEF.md
# Write-Busy Status Read Multiplexer

This block sits on the read-data path of a byte-wide non-volatile memory whose writes finish under an internal timer. While no internal write is running, each read returns the byte fetched from the array. While the busy flag is high, each read returns a status byte instead. The host polls that byte to learn how far the write has progressed and which protection and abort conditions apply.

The status byte packs five indicators:
- the complement of the top bit of the last byte written;
- a bit that alternates on every read;
- the load-timer expiry flag;
- the page-write abort flag;
- the protection state.

A read is counted once for each rising edge of the read strobe, however long the strobe stays high. The read value is registered on that edge and held until the next read. The alternating bit is cleared whenever a new busy window opens, so the first status read of every write returns 0 in that position.

Top module: `wr_status_mux`

## Requirements
- R1: While rst_n is low, rd_data is 8'h00 and the toggle state is cleared.
- R2: A read event is a rising edge of rd_stb seen at a clock edge. rd_data is loaded on that clock edge only and holds its value on every other cycle, including while rd_stb stays high.
- R3: On a read event with busy low, rd_data takes the value of arr_data.
- R4: On a read event with busy high, rd_data[7] equals the inverse of last_wr[7].
- R5: On read events with busy high, rd_data[6] alternates from one read to the next. The first read after busy rises returns 0, including a read that lands in the same cycle as the rise.
- R6: On a read event with busy high, rd_data[5] equals ltmr_expired, rd_data[1] equals pw_abort and rd_data[0] equals prot_on. Each bit follows its own input whatever the values of the others.
- R7: On a read event with busy high, rd_data[4:2] is 3'b000.
- R8: Once busy falls, reads return arr_data again and no toggling is visible. A later busy window restarts the alternating bit at 0, even if no read occurred when it opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe; its rising edge is one read |
| arr_data | input | 8 | Byte read from the array |
| last_wr | input | 8 | Last byte loaded by the host |
| busy | input | 1 | High while the internal write runs |
| ltmr_expired | input | 1 | Load timer has run out |
| pw_abort | input | 1 | Page write was aborted |
| prot_on | input | 1 | Software write protection enabled |
| rd_data | output | 8 | Registered read value |

## Verification
The clear of the toggle bit at the start of a write and the toggle of that bit caused by a read can fall on the same clock edge. The bench provokes this by raising busy and the read strobe at the same falling edge. It then expects that read to return 0 in bit 6 and the next read to return 1. A reference model in the bench predicts rd_data every cycle from the port stimulus, and a monitor compares the design against it one step after each rising edge. The bench also opens a busy window with no read in its first cycle, to confirm that the clear does not depend on a read being present.

// File: rtl/wr_status_mux.sv
module wr_status_mux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [DW-1:0] arr_data,
  input  logic [DW-1:0] last_wr,
  input  logic          busy,
  input  logic          ltmr_expired,
  input  logic          pw_abort,
  input  logic          prot_on,
  output logic [DW-1:0] rd_data
);
  localparam int POLL_B = DW - 1;
  localparam int TOG_B  = DW - 2;
  localparam int TMR_B  = DW - 3;
  localparam int ABT_B  = 1;
  localparam int PROT_B = 0;

  logic stb_q, busy_q, tog;

  wire rd_ev    = rd_stb & ~stb_q;
  wire wr_start = busy & ~busy_q;
  wire tog_now  = wr_start ? 1'b0 : tog;

  logic [DW-1:0] status;
  always_comb begin
    status         = '0;
    status[POLL_B] = ~last_wr[POLL_B];
    status[TOG_B]  = tog_now;
    status[TMR_B]  = ltmr_expired;
    status[ABT_B]  = pw_abort;
    status[PROT_B] = prot_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      busy_q  <= 1'b0;
      tog     <= 1'b0;
      rd_data <= '0;
    end else begin
      stb_q  <= rd_stb;
      busy_q <= busy;
      tog    <= (rd_ev && busy) ? ~tog_now : tog_now;
      if (rd_ev) rd_data <= busy ? status : arr_data;
    end
  end

  assert_hold_between_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(rd_data));
  assert_pass_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !busy) |=> rd_data == $past(arr_data));
  assert_poll_inverted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && busy) |=> rd_data[POLL_B] == ~$past(last_wr[POLL_B]));
  assert_first_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && wr_start) |=> rd_data[TOG_B] == 1'b0);
  assert_flags_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && busy) |=> (rd_data[PROT_B] == $past(prot_on)) && (rd_data[ABT_B] == $past(pw_abort))
                        && (rd_data[TMR_B] == $past(ltmr_expired)));
  assert_spare_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && busy) |=> rd_data[4:2] == 3'b000);
endmodule

// File: tb/wr_status_mux_test.sv
`timescale 1ns/1ps
module wr_status_mux_test;
  logic clk = 0, rst_n = 0, rd_stb = 0, busy = 0;
  logic ltmr_expired = 0, pw_abort = 0, prot_on = 0;
  logic [7:0] arr_data = 0, last_wr = 0, rd_data;
  int checks = 0, fails = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  wr_status_mux uut (.clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .arr_data(arr_data),
    .last_wr(last_wr), .busy(busy), .ltmr_expired(ltmr_expired), .pw_abort(pw_abort),
    .prot_on(prot_on), .rd_data(rd_data));

  logic [7:0] qv[$];
  string      qr[$];

  // reference model: predicts rd_data after each rising edge from the requirements
  logic m_stb, m_busy, m_tog, t;
  logic [7:0] m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stb = 0; m_busy = 0; m_tog = 0; m_rd = 0;
    end else begin
      t = (busy && !m_busy) ? 1'b0 : m_tog;
      if (rd_stb && !m_stb) begin
        m_rd = busy ? {~last_wr[7], t, ltmr_expired, 3'b000, pw_abort, prot_on} : arr_data;
        if (busy) t = ~t;
      end
      m_tog = t; m_stb = rd_stb; m_busy = busy;
      qv.push_back(m_rd);
      qr.push_back(cur_req);
    end
  end

  // monitor
  always @(posedge clk) begin
    #1;
    while (qv.size() > 0) begin
      logic [7:0] e;
      string r;
      e = qv.pop_front();
      r = qr.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: rd_data=%h expected=%h at %0t", r, rd_data, e, $time);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input int hold, input string req);
    @(negedge clk);
    cur_req = req; arr_data = a; rd_stb = 1;
    repeat (hold - 1) @(negedge clk);
    @(negedge clk);
    rd_stb = 0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 8'h00) begin
      fails++;
      $display("FAIL R1: rd_data=%h expected=00", rd_data);
    end
    rst_n = 1;
    rd(8'h5A, 1, "R3");
    rd(8'hC3, 1, "R3");
    rd(8'h11, 5, "R2");
    rd(8'hEE, 1, "R3");
    // busy rises in the same cycle as a read
    last_wr = 8'h80;
    @(negedge clk);
    cur_req = "R5"; busy = 1; rd_stb = 1; arr_data = 8'h77;
    @(negedge clk); rd_stb = 0;
    rd(8'h77, 1, "R5");
    rd(8'h77, 3, "R5");
    rd(8'h77, 1, "R4");
    ltmr_expired = 1; rd(8'h00, 1, "R6");
    pw_abort = 1;     rd(8'h00, 1, "R6");
    prot_on = 1;      rd(8'h00, 1, "R6");
    ltmr_expired = 0; pw_abort = 0; rd(8'hFF, 1, "R7");
    last_wr = 8'h35;  rd(8'hFF, 1, "R4");
    @(negedge clk); busy = 0;
    rd(8'h9C, 1, "R8");
    rd(8'h3D, 2, "R8");
    // new window opens without a read in its first cycle
    last_wr = 8'h7F; prot_on = 0; pw_abort = 1;
    @(negedge clk); busy = 1;
    repeat (3) @(negedge clk);
    rd(8'h00, 1, "R8");
    rd(8'h00, 1, "R5");
    rd(8'h00, 1, "R6");
    @(negedge clk); busy = 0; pw_abort = 0;
    rd(8'hA5, 1, "R3");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule